// File: doc/BRIEF.md
# Periodic Time and Calendar Event Flagger

This block watches the outputs of a running BCD time-of-day and date counter and keeps a small set of sticky event flags. Each time the counter advances it presents a one-cycle tick together with the new time and date. On every tick the block sets a second flag. It sets a time flag when the new time matches a selected trigger: every minute, every hour, midnight or noon. It sets a calendar flag when the new date and time match a selected trigger: start of week, start of month or start of year. Three further status bits are set by strobes from neighbouring logic (update acknowledge, alarm, time/date error). These bits are collected here so that all six share one clear word, one mask and one interrupt line.

A simple register port with a write strobe, a write address, write data, a read address and combinational read data sets the two trigger selections, clears flags, and sets or clears interrupt mask bits. The interrupt output is high while any flag is set whose mask bit is also set.

Top module: `event_flagger`

## Requirements
- R1: After a synchronous reset the status word, the mask word and the control word read 0 and `irq` is low.
- R2: A cycle with `tick` high sets status bit 2 (second). A flag stays set through later ticks until it is cleared.
- R3: The time trigger select (control bits 1:0) sets status bit 3 on a tick whose new time matches. Code 0 matches seconds 00. Code 1 matches minutes and seconds 00. Code 2 matches 00:00:00. Code 3 matches 12:00:00. All values are BCD.
- R4: With `hour12` high, midnight means hour 0x12 with `now_pm` low, and noon means hour 0x12 with `now_pm` high, in both cases at minutes and seconds 00.
- R5: The calendar trigger select (control bits 3:2) sets status bit 4 only on a tick at the start of the day (midnight as in R3/R4). Code 0 needs weekday 1 (Monday). Code 1 needs date 0x01. Code 2 needs date 0x01 and month 0x01.
- R6: Calendar select code 3 never sets status bit 4.
- R7: Writing the clear word (address 1) clears each status bit written as 1 and leaves bits written as 0 unchanged. A set and a clear of the same bit in the same cycle leave the bit set.
- R8: Writing address 2 sets each mask bit written as 1, and writing address 3 clears each mask bit written as 1. Zero bits have no effect. Writes to the status (4) or mask (5) address change nothing.
- R9: `irq` is high exactly while the status word ANDed with the mask word is nonzero. It follows from the cycle after the flag or mask change.
- R10: `aux_set` bits 0, 1 and 2 set status bits 0 (acknowledge), 1 (alarm) and 5 (time/date error), each sticky as in R2.
- R11: Register map: 0 control (read/write), 1 clear, 2 mask set, 3 mask clear, 4 status (read), 5 mask (read). Addresses 1, 2 and 3 read as 0. Flag, mask and clear bit positions are identical.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe: counter has just advanced |
| now_sec | input | 7 | Current seconds, BCD |
| now_min | input | 7 | Current minutes, BCD |
| now_hour | input | 6 | Current hour, BCD |
| now_pm | input | 1 | PM indicator (used when hour12 is high) |
| now_wday | input | 3 | Day of week, 1 = Monday |
| now_date | input | 6 | Day of month, BCD |
| now_month | input | 5 | Month, BCD |
| hour12 | input | 1 | Counter runs in 12-hour mode |
| aux_set | input | 3 | Set strobes for acknowledge, alarm, error flags |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| irq | output | 1 | Combined interrupt |

## Verification
A tick, aux strobe or register write that is driven in one cycle shows up in the status, mask and control reads right after the next rising edge. There is one register on each path, and `irq` is combinational from those registers. The driver applies each stimulus for exactly one cycle. It then queues the expected read for the following cycle. The monitor performs that read at the falling edge of the due cycle, after all updates have settled and before the next stimulus can take effect.

// File: rtl/evflag_pkg.sv
package evflag_pkg;

    localparam int unsigned FLAG_N = 6;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned ADDR_W = 3;
    localparam int unsigned SEL_W  = 2;

    // flag bit positions (shared by status, clear, mask words)
    localparam int unsigned F_ACK = 0;
    localparam int unsigned F_ALM = 1;
    localparam int unsigned F_SEC = 2;
    localparam int unsigned F_TIM = 3;
    localparam int unsigned F_CAL = 4;
    localparam int unsigned F_ERR = 5;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 3'd0,
        A_CLEAR  = 3'd1,
        A_MSET   = 3'd2,
        A_MCLR   = 3'd3,
        A_STATUS = 3'd4,
        A_MASK   = 3'd5
    } reg_addr_e;

    typedef enum logic [SEL_W-1:0] {
        TS_MINUTE = 2'd0,
        TS_HOUR   = 2'd1,
        TS_MIDN   = 2'd2,
        TS_NOON   = 2'd3
    } time_sel_e;

    typedef enum logic [SEL_W-1:0] {
        CS_WEEK  = 2'd0,
        CS_MONTH = 2'd1,
        CS_YEAR  = 2'd2,
        CS_NONE  = 2'd3
    } cal_sel_e;

    typedef struct packed {
        cal_sel_e  cal;
        time_sel_e tim;
    } ctrl_t;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [5:0] hour;
        logic       pm;
        logic [2:0] wday;
        logic [5:0] date;
        logic [4:0] month;
    } stamp_t;

    function automatic logic hour_is_midnight(input stamp_t s, input logic h12);
        return h12 ? (s.hour == 6'h12 && !s.pm) : (s.hour == 6'h00);
    endfunction

    function automatic logic hour_is_noon(input stamp_t s, input logic h12);
        return h12 ? (s.hour == 6'h12 && s.pm) : (s.hour == 6'h12);
    endfunction

endpackage

// File: rtl/evflag_detect.sv
module evflag_detect
    import evflag_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick_i,
    input  stamp_t    now_i,
    input  logic      hour12_i,
    input  ctrl_t     ctrl_i,
    output logic      sec_hit_o,
    output logic      tim_hit_o,
    output logic      cal_hit_o
);

    logic top_of_hour;
    logic day_start;
    logic noon_now;
    logic tim_match;
    logic cal_match;

    always_comb begin
        top_of_hour = (now_i.sec == 7'h00) && (now_i.min == 7'h00);
        day_start   = top_of_hour && hour_is_midnight(now_i, hour12_i);
        noon_now    = top_of_hour && hour_is_noon(now_i, hour12_i);

        unique case (ctrl_i.tim)
            TS_MINUTE: tim_match = (now_i.sec == 7'h00);
            TS_HOUR:   tim_match = top_of_hour;
            TS_MIDN:   tim_match = day_start;
            TS_NOON:   tim_match = noon_now;
            default:   tim_match = 1'b0;
        endcase

        unique case (ctrl_i.cal)
            CS_WEEK:  cal_match = (now_i.wday == 3'd1);
            CS_MONTH: cal_match = (now_i.date == 6'h01);
            CS_YEAR:  cal_match = (now_i.date == 6'h01) && (now_i.month == 5'h01);
            default:  cal_match = 1'b0;
        endcase
    end

    assign sec_hit_o = tick_i;
    assign tim_hit_o = tick_i && tim_match;
    assign cal_hit_o = tick_i && day_start && cal_match;

    // R5
    cal_at_midnight_chk: assert property (@(posedge clk) disable iff (rst)
        cal_hit_o |-> (tick_i && now_i.sec == 7'h00 && now_i.min == 7'h00));

    // R3
    tim_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
        tim_hit_o |-> sec_hit_o);

endmodule

// File: rtl/evflag_flags.sv
module evflag_flags #(
    parameter int unsigned N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);

    logic [N-1:0] flags_q;

    for (genvar k = 0; k < N; k++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                flags_q[k] <= 1'b0;
            else if (set_i[k])
                flags_q[k] <= 1'b1;
            else if (clr_i[k])
                flags_q[k] <= 1'b0;
        end

        // R2
        set_sticks_chk: assert property (@(posedge clk) disable iff (rst)
            set_i[k] |=> flags_q[k]);

        // R7
        clr_drops_chk: assert property (@(posedge clk) disable iff (rst)
            (clr_i[k] && !set_i[k]) |=> !flags_q[k]);

        // R2
        idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (!clr_i[k] && !set_i[k]) |=> $stable(flags_q[k]));
    end

    assign flags_o = flags_q;

endmodule

// File: rtl/evflag_mask.sv
module evflag_mask #(
    parameter int unsigned N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] en_i,
    input  logic [N-1:0] dis_i,
    input  logic [N-1:0] flags_i,
    output logic [N-1:0] mask_o,
    output logic         irq_o
);

    logic [N-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else
            mask_q <= (mask_q | en_i) & ~(dis_i & ~en_i);
    end

    assign mask_o = mask_q;
    assign irq_o  = |(flags_i & mask_q);

    for (genvar k = 0; k < N; k++) begin : g_chk
        // R8
        en_sets_chk: assert property (@(posedge clk) disable iff (rst)
            en_i[k] |=> mask_q[k]);

        // R8
        dis_clears_chk: assert property (@(posedge clk) disable iff (rst)
            (dis_i[k] && !en_i[k]) |=> !mask_q[k]);

        // R8
        mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (!en_i[k] && !dis_i[k]) |=> $stable(mask_q[k]));
    end

endmodule

// File: rtl/event_flagger.sv
module event_flagger
    import evflag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [6:0]        now_sec,
    input  logic [6:0]        now_min,
    input  logic [5:0]        now_hour,
    input  logic              now_pm,
    input  logic [2:0]        now_wday,
    input  logic [5:0]        now_date,
    input  logic [4:0]        now_month,
    input  logic              hour12,
    input  logic [2:0]        aux_set,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);

    localparam int unsigned CTRL_W = $bits(ctrl_t);

    ctrl_t             ctrl_q;
    stamp_t            now;
    logic              sec_hit, tim_hit, cal_hit;
    logic [FLAG_N-1:0] set_vec, clr_vec, en_vec, dis_vec;
    logic [FLAG_N-1:0] status, mask;
    logic              unused_hi;

    assign now = '{sec: now_sec, min: now_min, hour: now_hour, pm: now_pm,
                   wday: now_wday, date: now_date, month: now_month};

    // control register
    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (wr_en && wr_addr == A_CTRL)
            ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
    end

    evflag_detect u_detect (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (tick),
        .now_i    (now),
        .hour12_i (hour12),
        .ctrl_i   (ctrl_q),
        .sec_hit_o(sec_hit),
        .tim_hit_o(tim_hit),
        .cal_hit_o(cal_hit)
    );

    always_comb begin
        set_vec        = '0;
        set_vec[F_ACK] = aux_set[0];
        set_vec[F_ALM] = aux_set[1];
        set_vec[F_SEC] = sec_hit;
        set_vec[F_TIM] = tim_hit;
        set_vec[F_CAL] = cal_hit;
        set_vec[F_ERR] = aux_set[2];
        clr_vec = (wr_en && wr_addr == A_CLEAR) ? wr_data[FLAG_N-1:0] : '0;
        en_vec  = (wr_en && wr_addr == A_MSET)  ? wr_data[FLAG_N-1:0] : '0;
        dis_vec = (wr_en && wr_addr == A_MCLR)  ? wr_data[FLAG_N-1:0] : '0;
    end

    assign unused_hi = ^wr_data[DATA_W-1:FLAG_N];

    evflag_flags #(.N(FLAG_N)) u_flags (
        .clk    (clk),
        .rst    (rst),
        .set_i  (set_vec),
        .clr_i  (clr_vec),
        .flags_o(status)
    );

    evflag_mask #(.N(FLAG_N)) u_mask (
        .clk    (clk),
        .rst    (rst),
        .en_i   (en_vec),
        .dis_i  (dis_vec),
        .flags_i(status),
        .mask_o (mask),
        .irq_o  (irq)
    );

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_CTRL:   rd_data[CTRL_W-1:0] = ctrl_q;
            A_STATUS: rd_data[FLAG_N-1:0] = status;
            A_MASK:   rd_data[FLAG_N-1:0] = mask;
            default:  rd_data = '0;
        endcase
    end

    // R6
    cal_none_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.cal == CS_NONE && !status[F_CAL]) |=> !status[F_CAL]);

    // R9
    irq_src_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (status != '0 && mask != '0));

    // R1
    reset_clean_chk: assert property (@(posedge clk)
        $past(rst) |-> (status == '0 && mask == '0 && !irq));

endmodule

// File: tb/event_flagger_bench.sv
`timescale 1ns/1ps
module event_flagger_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [6:0] now_sec = '0, now_min = '0;
    logic [5:0] now_hour = '0;
    logic       now_pm = 1'b0;
    logic [2:0] now_wday = 3'd1;
    logic [5:0] now_date = 6'h15;
    logic [4:0] now_month = 5'h06;
    logic       hour12 = 1'b0;
    logic [2:0] aux_set = '0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = 3'd4;
    logic [7:0] rd_data;
    logic       irq;

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    event_flagger u_event_flagger (
        .clk(clk), .rst(rst), .tick(tick),
        .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour), .now_pm(now_pm),
        .now_wday(now_wday), .now_date(now_date), .now_month(now_month),
        .hour12(hour12), .aux_set(aux_set),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    typedef struct {
        logic [2:0] addr;
        logic [7:0] data;
        logic       irq;
        bit         chk_irq;
        string      tag;
        int         due;
    } exp_t;

    exp_t sbq[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 0;

    // scoreboard push
    task automatic expect_rd(input logic [2:0] a, input logic [7:0] d, input string tag);
        exp_t e;
        e.addr = a; e.data = d; e.irq = 1'b0; e.chk_irq = 1'b0; e.tag = tag; e.due = cyc + 1;
        sbq.push_back(e);
    endtask

    task automatic expect_st(input logic [7:0] d, input logic i, input string tag);
        exp_t e;
        e.addr = 3'd4; e.data = d; e.irq = i; e.chk_irq = 1'b1; e.tag = tag; e.due = cyc + 1;
        sbq.push_back(e);
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic set_now(input logic [6:0] h_s, input logic [6:0] h_m, input logic [5:0] h_h,
                           input logic p, input logic [2:0] wd, input logic [5:0] dt,
                           input logic [4:0] mo);
        now_sec = h_s; now_min = h_m; now_hour = h_h; now_pm = p;
        now_wday = wd; now_date = dt; now_month = mo;
    endtask

    task automatic pulse(input bit t, input logic [2:0] ax);
        @(negedge clk); tick = t; aux_set = ax;
        @(negedge clk); tick = 1'b0; aux_set = '0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic tick_clr(input logic [7:0] d);
        @(negedge clk); tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd1; wr_data = d;
        @(negedge clk); tick = 1'b0; wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic clr_all();
        wr(3'd1, 8'h3F);
    endtask

    // monitor
    exp_t m;
    initial begin
        forever begin
            @(negedge clk);
            while (sbq.size() > 0 && sbq[0].due <= cyc) begin
                m = sbq.pop_front();
                rd_addr = m.addr;
                #0.5;
                checks++;
                if (rd_data !== m.data) begin
                    fails++;
                    $display("FAIL %s: addr %0d read %h expected %h", m.tag, m.addr, rd_data, m.data);
                end
                if (m.chk_irq && irq !== m.irq) begin
                    fails++;
                    $display("FAIL %s: irq %b expected %b", m.tag, irq, m.irq);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run not finished, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        expect_rd(3'd0, 8'h00, "R1 ctrl");
        expect_rd(3'd5, 8'h00, "R1 mask");
        expect_st(8'h00, 1'b0, "R1 status");
        settle();

        // R2 second flag and stickiness
        set_now(7'h56, 7'h34, 6'h12, 0, 3'd3, 6'h15, 5'h06);
        pulse(1, 3'b000); expect_st(8'h04, 0, "R2 second"); settle();
        set_now(7'h57, 7'h34, 6'h12, 0, 3'd3, 6'h15, 5'h06);
        pulse(1, 3'b000); expect_st(8'h04, 0, "R2 sticky"); settle();

        // R7 clear word
        wr(3'd1, 8'h00); expect_st(8'h04, 0, "R7 zero clear"); settle();
        wr(3'd1, 8'h04); expect_st(8'h00, 0, "R7 clear"); settle();

        // R3 minute
        set_now(7'h00, 7'h35, 6'h12, 0, 3'd3, 6'h15, 5'h06);
        pulse(1, 0); expect_st(8'h0C, 0, "R3 minute"); settle(); clr_all();

        // R3 hour
        wr(3'd0, 8'h01); expect_rd(3'd0, 8'h01, "R11 ctrl readback"); settle();
        pulse(1, 0); expect_st(8'h04, 0, "R3 hour no"); settle(); clr_all();
        set_now(7'h00, 7'h00, 6'h13, 0, 3'd3, 6'h15, 5'h06);
        pulse(1, 0); expect_st(8'h0C, 0, "R3 hour yes"); settle(); clr_all();

        // R3 midnight 24h
        wr(3'd0, 8'h02);
        set_now(7'h00, 7'h00, 6'h12, 0, 3'd3, 6'h15, 5'h06);
        pulse(1, 0); expect_st(8'h04, 0, "R3 midnight no"); settle(); clr_all();
        set_now(7'h00, 7'h00, 6'h00, 0, 3'd3, 6'h15, 5'h06);
        pulse(1, 0); expect_st(8'h0C, 0, "R3 midnight yes"); settle(); clr_all();

        // R3 noon 24h
        wr(3'd0, 8'h03);
        set_now(7'h00, 7'h00, 6'h12, 0, 3'd3, 6'h15, 5'h06);
        pulse(1, 0); expect_st(8'h0C, 0, "R3 noon yes"); settle(); clr_all();
        set_now(7'h00, 7'h00, 6'h00, 0, 3'd3, 6'h15, 5'h06);
        pulse(1, 0); expect_st(8'h04, 0, "R3 noon no"); settle(); clr_all();

        // R4 12-hour mode
        hour12 = 1'b1;
        wr(3'd0, 8'h02);
        set_now(7'h00, 7'h00, 6'h12, 0, 3'd3, 6'h15, 5'h06);
        pulse(1, 0); expect_st(8'h0C, 0, "R4 midnight 12AM"); settle(); clr_all();
        set_now(7'h00, 7'h00, 6'h12, 1, 3'd3, 6'h15, 5'h06);
        pulse(1, 0); expect_st(8'h04, 0, "R4 midnight not 12PM"); settle(); clr_all();
        wr(3'd0, 8'h03);
        pulse(1, 0); expect_st(8'h0C, 0, "R4 noon 12PM"); settle(); clr_all();
        set_now(7'h00, 7'h00, 6'h12, 0, 3'd3, 6'h15, 5'h06);
        pulse(1, 0); expect_st(8'h04, 0, "R4 noon not 12AM"); settle(); clr_all();
        hour12 = 1'b0;

        // R5 week
        wr(3'd0, 8'h01);
        set_now(7'h00, 7'h00, 6'h00, 0, 3'd1, 6'h15, 5'h06);
        pulse(1, 0); expect_st(8'h1C, 0, "R5 week Monday"); settle(); clr_all();
        set_now(7'h00, 7'h00, 6'h00, 0, 3'd2, 6'h15, 5'h06);
        pulse(1, 0); expect_st(8'h0C, 0, "R5 week Tuesday"); settle(); clr_all();
        set_now(7'h00, 7'h00, 6'h01, 0, 3'd1, 6'h15, 5'h06);
        pulse(1, 0); expect_st(8'h0C, 0, "R5 week not midnight"); settle(); clr_all();

        // R5 month
        wr(3'd0, 8'h05);
        set_now(7'h00, 7'h00, 6'h00, 0, 3'd3, 6'h01, 5'h06);
        pulse(1, 0); expect_st(8'h1C, 0, "R5 month first"); settle(); clr_all();
        set_now(7'h00, 7'h00, 6'h00, 0, 3'd3, 6'h02, 5'h06);
        pulse(1, 0); expect_st(8'h0C, 0, "R5 month second day"); settle(); clr_all();

        // R5 year
        wr(3'd0, 8'h09);
        set_now(7'h00, 7'h00, 6'h00, 0, 3'd3, 6'h01, 5'h01);
        pulse(1, 0); expect_st(8'h1C, 0, "R5 year jan1"); settle();
        set_now(7'h01, 7'h00, 6'h00, 0, 3'd3, 6'h01, 5'h01);
        pulse(1, 0); expect_st(8'h1C, 0, "R5 calendar sticky"); settle(); clr_all();
        set_now(7'h00, 7'h00, 6'h00, 0, 3'd3, 6'h01, 5'h02);
        pulse(1, 0); expect_st(8'h0C, 0, "R5 year feb1"); settle(); clr_all();

        // R6 reserved calendar code
        wr(3'd0, 8'h0D); expect_rd(3'd0, 8'h0D, "R6 ctrl code3"); settle();
        set_now(7'h00, 7'h00, 6'h00, 0, 3'd1, 6'h01, 5'h01);
        pulse(1, 0); expect_st(8'h0C, 0, "R6 never fires"); settle(); clr_all();

        // R7 set wins over clear
        set_now(7'h11, 7'h22, 6'h05, 0, 3'd3, 6'h15, 5'h06);
        tick_clr(8'h04); expect_st(8'h04, 0, "R7 set wins"); settle(); clr_all();

        // R8 / R9 mask and irq
        wr(3'd2, 8'h04); expect_rd(3'd5, 8'h04, "R8 mask set"); expect_st(8'h00, 0, "R9 no flag"); settle();
        pulse(1, 0); expect_st(8'h04, 1, "R9 irq asserted"); settle();
        wr(3'd2, 8'h00); expect_rd(3'd5, 8'h04, "R8 zero enable"); settle();
        wr(3'd5, 8'hFF); expect_rd(3'd5, 8'h04, "R8 mask read-only"); settle();
        wr(3'd4, 8'hFF); expect_st(8'h04, 1, "R8 status read-only"); settle();
        wr(3'd3, 8'h00); expect_rd(3'd5, 8'h04, "R8 zero disable"); settle();
        wr(3'd3, 8'h04); expect_rd(3'd5, 8'h00, "R8 mask clear"); expect_st(8'h04, 0, "R9 irq off"); settle();
        wr(3'd2, 8'h08); expect_st(8'h04, 0, "R9 unmatched mask"); settle();
        clr_all(); wr(3'd3, 8'h3F); expect_rd(3'd5, 8'h00, "R8 all clear"); settle();

        // R10 aux flags
        pulse(0, 3'b001); expect_st(8'h01, 0, "R10 ack"); settle();
        pulse(0, 3'b010); expect_st(8'h03, 0, "R10 alarm"); settle();
        pulse(0, 3'b100); expect_st(8'h23, 0, "R10 error"); settle();
        wr(3'd2, 8'h20); expect_st(8'h23, 1, "R9 irq from error"); settle();
        clr_all(); expect_st(8'h00, 0, "R9 irq after clear"); settle();

        // R11 write-only addresses read zero
        expect_rd(3'd1, 8'h00, "R11 clear reads 0");
        expect_rd(3'd2, 8'h00, "R11 mset reads 0");
        settle();

        while (sbq.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule